// File: doc/BRIEF.md
# Serial Receiver with Per-Character Error Flags

This block receives asynchronous serial characters from an oversampled line and queues them in a receive FIFO. Each character is stored together with its own parity, framing and break flags. The character length is 5 to 8 bits. Parity can be off, even or odd. One or two stop bits can be selected. A sample-enable pulse at sixteen times the bit rate paces all line timing. A baud generator outside the block supplies that pulse.

A host uses two read strobes. One reads the data at the FIFO head. The other reads an 8-bit line status word. The error flags of a character show in the status word only while that character sits at the FIFO head. A status read acknowledges them. An overrun bit reports a character lost to a full FIFO. An aggregate bit reports that flagged characters are still queued. When enabled, a line-status interrupt request goes out while any error indication is showing.

The receiver recovers from a bad stop bit by treating that bit as the start of the next character. A long low line is reported as a single break character. After a break, the line must be idle before reception starts again.

Top module: `uart_rx_errfifo`

## Requirements
- R1: After reset, `lsr_o` is 8'h00 and `irq_o` is 0. Bits 6 and 5 of `lsr_o` are always 0.
- R2: `data_bits_i` codes 0..3 select 5..8 data bits. Data arrives LSB first and is presented right-aligned on `rx_data_o`, with the unused upper bits zero. `lsr_o[0]` is 1 while the FIFO holds a character. A pulse on `rd_data_i` removes the head character.
- R3: When `parity_en_i` is 1, a parity bit follows the data. Its expected value makes the count of ones even (`parity_even_i`=1) or odd (`parity_even_i`=0). On a mismatch the character's parity flag is set; it is shown in `lsr_o[2]`.
- R4: Each bit is sampled near the middle of its 16 ticks. A low pulse that is high again by the middle of the start bit is discarded, and no character is produced.
- R5: A zero sampled in the first stop-bit position sets the character's framing flag; it is shown in `lsr_o[3]`.
- R6: After a framing error on a non-zero frame, the zero stop bit is taken as the next start bit. It is sampled once more, and data bits are then collected without waiting for a new falling edge.
- R7: If the line stays low for more than one full character time, a single character 8'h00 is queued with only its break flag set (`lsr_o[4]`). This holds however long the line stays low. An all-zero frame whose low time is exactly one character time is queued as 8'h00 with the framing flag set instead.
- R8: After a break, a falling edge is ignored until the line has been high for at least half a bit time (8 ticks).
- R9: The parity, framing and break flags are shown only while their character is at the FIFO head. A status read (`rd_lsr_i`) clears them for that head character.
- R10: `lsr_o[1]` is set when a character completes while the FIFO is full. That character is discarded. The bit is cleared by a status read. The FIFO holds `DEPTH` characters when `fifo_en_i`=1 and one character when `fifo_en_i`=0.
- R11: `lsr_o[7]` is 0 when `fifo_en_i`=0. When `fifo_en_i`=1, it is set while any queued character carries a flag. A status read clears it only if no flagged character remains.
- R12: `irq_o` is 1 exactly when `lsi_en_i` is 1 and any of `lsr_o[4:1]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample enable at 16x the bit rate |
| rxd_i | input | 1 | Serial line, idle high |
| data_bits_i | input | 2 | Data length code, 0..3 selects 5..8 bits |
| parity_en_i | input | 1 | Parity bit present |
| parity_even_i | input | 1 | 1 selects even parity, 0 selects odd parity |
| stop2_i | input | 1 | Two stop bits |
| fifo_en_i | input | 1 | 1 selects FIFO mode, 0 selects single holding register |
| lsi_en_i | input | 1 | Line-status interrupt enable |
| rd_data_i | input | 1 | Read strobe for the head character (pops the FIFO) |
| rd_lsr_i | input | 1 | Read strobe for the line status word |
| rx_data_o | output | 8 | Head character |
| lsr_o | output | 8 | Line status word |
| irq_o | output | 1 | Line-status interrupt request |

## Verification
The checker watches several invariants on every cycle:
- the FIFO fill never exceeds its depth;
- a shown flag always has a character behind it;
- a break indication always comes with a zero character;
- a status read clears the head flags and the overrun bit;
- the aggregate bit stays zero outside FIFO mode and holds until a read;
- the interrupt follows its enable.

Only the bench scenarios can show the serial timing behaviour:
- resynchronisation after a bad stop bit;
- the exact boundary between a zero character with a framing error and a break;
- the idle time required after a break;
- glitch rejection;
- parity across the supported lengths.

For each of these, the bench compares the stream of queued characters and their flags against its own model.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef struct packed {
    logic [7:0] data;
    logic       bi;
    logic       fe;
    logic       pe;
  } rx_char_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_RESYNC,
    S_BRK_CHK,
    S_BRK_WAIT
  } rx_state_e;

endpackage

// File: rtl/rx_deframer.sv
module rx_deframer
  import uart_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic [1:0] data_bits_i,
  input  logic       parity_en_i,
  input  logic       parity_even_i,
  input  logic       stop2_i,
  output logic       push_o,
  output rx_char_t   char_o
);

  localparam int CNT_W    = $clog2(OVS);
  localparam int HALF     = OVS / 2;
  localparam int MAX_BITS = 12;
  localparam int RUN_W    = $clog2(OVS * MAX_BITS + 1) + 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rxd_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], rxd_i};
  end
  assign rxd_s = sync_q[SYNC_STAGES-1];

  rx_state_e        state_q;
  logic [CNT_W-1:0] tick_cnt;
  logic [2:0]       bit_idx;
  logic [7:0]       data_q;
  logic             par_q;
  logic [RUN_W-1:0] low_run;
  logic             push_q;
  rx_char_t         char_q;

  logic [2:0]       last_idx;
  logic [3:0]       frame_bits;
  logic [RUN_W-1:0] char_ticks;
  logic             par_calc, pe_calc, at_end, at_half;

  always_comb begin
    last_idx   = 3'd4 + {1'b0, data_bits_i};
    frame_bits = 4'd7 + {2'b00, data_bits_i} + {3'b000, parity_en_i} + {3'b000, stop2_i};
    char_ticks = RUN_W'(frame_bits) * RUN_W'(OVS);
    par_calc   = (^data_q) ^ par_q;
    pe_calc    = parity_en_i & (parity_even_i ? par_calc : ~par_calc);
    at_end     = tick_cnt == CNT_W'(OVS - 1);
    at_half    = tick_cnt == CNT_W'(HALF - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      tick_cnt <= '0;
      bit_idx  <= '0;
      data_q   <= '0;
      par_q    <= 1'b0;
      low_run  <= '0;
      push_q   <= 1'b0;
      char_q   <= '0;
    end else begin
      push_q <= 1'b0;
      if (tick_i) begin
        if (rxd_s)              low_run <= '0;
        else if (low_run != '1) low_run <= low_run + RUN_W'(1);

        unique case (state_q)
          S_IDLE: if (!rxd_s) begin
            state_q  <= S_START;
            tick_cnt <= '0;
            bit_idx  <= '0;
            data_q   <= '0;
            par_q    <= 1'b0;
          end
          S_START: begin
            if (at_half) begin
              tick_cnt <= '0;
              state_q  <= rxd_s ? S_IDLE : S_DATA;  // glitch check at mid start
            end else tick_cnt <= tick_cnt + CNT_W'(1);
          end
          S_DATA: begin
            if (at_end) begin
              tick_cnt        <= '0;
              data_q[bit_idx] <= rxd_s;
              bit_idx         <= bit_idx + 3'd1;
              if (bit_idx == last_idx) state_q <= parity_en_i ? S_PAR : S_STOP;
            end else tick_cnt <= tick_cnt + CNT_W'(1);
          end
          S_PAR: begin
            if (at_end) begin
              tick_cnt <= '0;
              par_q    <= rxd_s;
              state_q  <= S_STOP;
            end else tick_cnt <= tick_cnt + CNT_W'(1);
          end
          S_STOP: begin
            if (at_end) begin
              tick_cnt <= '0;
              if (rxd_s) begin
                push_q  <= 1'b1;
                char_q  <= '{data: data_q, bi: 1'b0, fe: 1'b0, pe: pe_calc};
                state_q <= S_IDLE;
              end else if (data_q == '0 && !par_q) begin
                state_q <= S_BRK_CHK;  // could still turn into a break
              end else begin
                push_q  <= 1'b1;
                char_q  <= '{data: data_q, bi: 1'b0, fe: 1'b1, pe: pe_calc};
                state_q <= S_RESYNC;
              end
            end else tick_cnt <= tick_cnt + CNT_W'(1);
          end
          S_RESYNC: begin
            // bad stop bit taken as next start: second sample
            if (rxd_s) state_q <= S_IDLE;
            else begin
              state_q  <= S_DATA;
              tick_cnt <= CNT_W'(1);
              bit_idx  <= '0;
              data_q   <= '0;
              par_q    <= 1'b0;
            end
          end
          S_BRK_CHK: begin
            if (rxd_s) begin
              push_q  <= 1'b1;
              char_q  <= '{data: 8'h00, bi: 1'b0, fe: 1'b1, pe: pe_calc};
              state_q <= S_IDLE;
            end else if (low_run >= char_ticks) begin
              push_q   <= 1'b1;
              char_q   <= '{data: 8'h00, bi: 1'b1, fe: 1'b0, pe: 1'b0};
              state_q  <= S_BRK_WAIT;
              tick_cnt <= '0;
            end
          end
          S_BRK_WAIT: begin
            if (!rxd_s)       tick_cnt <= '0;
            else if (at_half) state_q  <= S_IDLE;
            else              tick_cnt <= tick_cnt + CNT_W'(1);
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign push_o = push_q;
  assign char_o = char_q;

endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       fifo_en_i,
  input  logic                       push_i,
  input  rx_char_t                   char_i,
  input  logic                       pop_i,
  output rx_char_t                   head_o,
  output logic [$clog2(DEPTH+1)-1:0] fill_o,
  output logic                       overrun_o,
  output logic                       popped_o,
  output logic                       flag_pend_o
);

  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FILL_W = $clog2(DEPTH + 1);

  rx_char_t          mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [FILL_W-1:0] fill_q, err_q, err_d, cap;
  logic              full, do_push, do_pop, in_flag, out_flag;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    cap      = fifo_en_i ? FILL_W'(DEPTH) : FILL_W'(1);
    full     = fill_q >= cap;
    do_push  = push_i & ~full;
    do_pop   = pop_i & (fill_q != '0);
    head_o   = mem[rd_ptr];
    in_flag  = char_i.pe | char_i.fe | char_i.bi;
    out_flag = head_o.pe | head_o.fe | head_o.bi;
    err_d    = err_q + FILL_W'(do_push & in_flag) - FILL_W'(do_pop & out_flag);
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= char_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill_q <= '0;
      err_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      fill_q <= fill_q + FILL_W'(do_push) - FILL_W'(do_pop);
      err_q  <= err_d;
    end
  end

  assign fill_o      = fill_q;
  assign overrun_o   = push_i & full;
  assign popped_o    = do_pop;
  assign flag_pend_o = err_d != '0;

endmodule

// File: rtl/rx_status.sv
module rx_status
  import uart_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fifo_en_i,
  input  logic       lsi_en_i,
  input  logic       rd_lsr_i,
  input  logic       fill_nz_i,
  input  rx_char_t   head_i,
  input  logic       popped_i,
  input  logic       overrun_i,
  input  logic       flag_pend_i,
  output logic [7:0] lsr_o,
  output logic       irq_o
);

  logic ack_q, oe_q, agg_q, show;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      oe_q  <= 1'b0;
      agg_q <= 1'b0;
    end else begin
      // head acknowledged by a status read until the head changes
      if (!fill_nz_i || popped_i) ack_q <= 1'b0;
      else if (rd_lsr_i)          ack_q <= 1'b1;
      oe_q  <= overrun_i | (oe_q & ~rd_lsr_i);
      agg_q <= fifo_en_i & (flag_pend_i | (agg_q & ~rd_lsr_i));
    end
  end

  assign show  = fill_nz_i & ~ack_q;
  assign lsr_o = {agg_q, 2'b00, show & head_i.bi, show & head_i.fe,
                  show & head_i.pe, oe_q, fill_nz_i};
  assign irq_o = lsi_en_i & (|lsr_o[4:1]);

endmodule

// File: rtl/uart_rx_errfifo.sv
module uart_rx_errfifo
  import uart_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic [1:0] data_bits_i,
  input  logic       parity_en_i,
  input  logic       parity_even_i,
  input  logic       stop2_i,
  input  logic       fifo_en_i,
  input  logic       lsi_en_i,
  input  logic       rd_data_i,
  input  logic       rd_lsr_i,
  output logic [7:0] rx_data_o,
  output logic [7:0] lsr_o,
  output logic       irq_o
);

  localparam int FILL_W = $clog2(DEPTH + 1);

  logic              push, overrun, popped, flag_pend;
  rx_char_t          new_char, head;
  logic [FILL_W-1:0] fill;

  rx_deframer #(.OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_deframer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick_i),
    .rxd_i         (rxd_i),
    .data_bits_i   (data_bits_i),
    .parity_en_i   (parity_en_i),
    .parity_even_i (parity_even_i),
    .stop2_i       (stop2_i),
    .push_o        (push),
    .char_o        (new_char)
  );

  rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fifo_en_i   (fifo_en_i),
    .push_i      (push),
    .char_i      (new_char),
    .pop_i       (rd_data_i),
    .head_o      (head),
    .fill_o      (fill),
    .overrun_o   (overrun),
    .popped_o    (popped),
    .flag_pend_o (flag_pend)
  );

  rx_status u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fifo_en_i   (fifo_en_i),
    .lsi_en_i    (lsi_en_i),
    .rd_lsr_i    (rd_lsr_i),
    .fill_nz_i   (fill != '0),
    .head_i      (head),
    .popped_i    (popped),
    .overrun_i   (overrun),
    .flag_pend_i (flag_pend),
    .lsr_o       (lsr_o),
    .irq_o       (irq_o)
  );

  assign rx_data_o = head.data;

endmodule

// File: rtl/uart_rx_errfifo_chk.sv
module uart_rx_errfifo_chk #(
  parameter int DEPTH  = 16,
  parameter int FILL_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fifo_en_i,
  input logic              lsi_en_i,
  input logic              rd_lsr_i,
  input logic              rd_data_i,
  input logic [7:0]        lsr_o,
  input logic [7:0]        rx_data_o,
  input logic              irq_o,
  input logic [FILL_W-1:0] fill_i,
  input logic              overrun_i
);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i <= FILL_W'(DEPTH));  // R10
  AST_OVR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lsr_i && !overrun_i |=> !lsr_o[1]);  // R10
  AST_FLAG_HAS_CHAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lsr_o[4:2]) |-> lsr_o[0]);  // R9
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lsr_i && lsr_o[0] && !rd_data_i |=> lsr_o[4:2] == 3'b000);  // R9
  AST_BREAK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsr_o[4] |-> rx_data_o == 8'h00);  // R7
  AST_AGG_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i |=> !lsr_o[7]);  // R11
  AST_AGG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_en_i && lsr_o[7] && !rd_lsr_i |=> lsr_o[7]);  // R11
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> lsi_en_i);  // R12
  AST_IRQ_OVR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsi_en_i && lsr_o[1] |-> irq_o);  // R12
  AST_TX_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsr_o[6:5] == 2'b00);  // R1

endmodule

bind uart_rx_errfifo uart_rx_errfifo_chk #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .fifo_en_i (fifo_en_i),
  .lsi_en_i  (lsi_en_i),
  .rd_lsr_i  (rd_lsr_i),
  .rd_data_i (rd_data_i),
  .lsr_o     (lsr_o),
  .rx_data_o (rx_data_o),
  .irq_o     (irq_o),
  .fill_i    (fill),
  .overrun_i (overrun)
);

// File: tb/tb_uart_rx_errfifo.sv
module tb_uart_rx_errfifo;

  typedef struct packed {
    logic [7:0] d;
    logic       bi;
    logic       fe;
    logic       pe;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] dbits = 2'd3;
  logic       pen = 1'b0, even = 1'b1, stop2 = 1'b0;
  logic       fifo_en = 1'b1, lsi_en = 1'b0;
  logic       mon_lsr = 1'b0, mon_dat = 1'b0, tst_lsr = 1'b0, tst_dat = 1'b0;
  logic       rd_lsr, rd_data;
  logic [7:0] rx_data, lsr;
  logic       irq;
  bit         mon_en = 1'b0;
  bit         done = 1'b0;
  int         n_run = 0, n_fail = 0;
  exp_t       exp_q[$];

  assign rd_lsr  = mon_lsr | tst_lsr;
  assign rd_data = mon_dat | tst_dat;

  always #2 clk = ~clk;

  uart_rx_errfifo dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(1'b1), .rxd_i(rxd),
    .data_bits_i(dbits), .parity_en_i(pen), .parity_even_i(even), .stop2_i(stop2),
    .fifo_en_i(fifo_en), .lsi_en_i(lsi_en), .rd_data_i(rd_data), .rd_lsr_i(rd_lsr),
    .rx_data_o(rx_data), .lsr_o(lsr), .irq_o(irq)
  );

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mask_of();
    return 8'hFF >> (3 - dbits);
  endfunction

  task automatic push_exp(input logic [7:0] d, input logic bi, input logic fe, input logic pe);
    exp_q.push_back('{d: d & mask_of(), bi: bi, fe: fe, pe: pe});
  endtask

  task automatic send_bit(input logic v);
    rxd = v;
    repeat (16) @(negedge clk);
  endtask

  task automatic send_data(input logic [7:0] d, input logic bad_par, input logic stop_v, input int idle);
    logic [7:0] m;
    logic       p;
    m = d & mask_of();
    for (int i = 0; i < 5 + int'(dbits); i++) send_bit(m[i]);
    if (pen) begin
      p = even ? ^m : ~^m;
      send_bit(p ^ bad_par);
    end
    send_bit(stop_v);
    if (stop2 && stop_v) send_bit(1'b1);
    rxd = 1'b1;
    repeat (idle) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic bad_par, input logic stop_v, input int idle);
    send_bit(1'b0);
    send_data(d, bad_par, stop_v, idle);
  endtask

  task automatic pulse_lsr();
    tst_lsr = 1'b1;
    @(negedge clk);
    tst_lsr = 1'b0;
  endtask

  task automatic pulse_dat();
    tst_dat = 1'b1;
    @(negedge clk);
    tst_dat = 1'b0;
  endtask

  task automatic drain(input string tag);
    int g;
    g = 0;
    while (exp_q.size() != 0 && g < 5000) begin
      @(negedge clk);
      g++;
    end
    repeat (4) @(negedge clk);
    chk_eq(tag, exp_q.size(), 0);
  endtask

  // monitor: scoreboard pop and compare
  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (mon_en && lsr[0] === 1'b1) begin
        if (exp_q.size() == 0) begin
          chk_eq("R2 unexpected character", {24'h0, rx_data}, 32'hFFFF_FFFF);
        end else begin
          e = exp_q.pop_front();
          chk_eq("R2 character data", rx_data, e.d);
          chk_eq("R3/R5/R7 head flags {bi,fe,pe}", lsr[4:2], {e.bi, e.fe, e.pe});
        end
        mon_lsr = 1'b1;
        @(negedge clk);
        mon_lsr = 1'b0;
        mon_dat = 1'b1;
        @(negedge clk);
        mon_dat = 1'b0;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk_eq("R1 reset status", lsr, 8'h00);
    chk_eq("R1 reset irq", irq, 0);

    mon_en = 1'b1;
    // R2: 8N1
    push_exp(8'hA5, 0, 0, 0); send_frame(8'hA5, 0, 1, 20);
    push_exp(8'h3C, 0, 0, 0); send_frame(8'h3C, 0, 1, 20);
    drain("R2 8N1 stream");

    // R3: 7 bits even parity
    dbits = 2'd2; pen = 1'b1; even = 1'b1;
    push_exp(8'h35, 0, 0, 0); send_frame(8'h35, 0, 1, 20);
    push_exp(8'h35, 0, 0, 1); send_frame(8'h35, 1, 1, 20);
    drain("R3 even parity");

    // R3: 5 bits odd parity, two stop bits
    dbits = 2'd0; even = 1'b0; stop2 = 1'b1;
    push_exp(8'h1B, 0, 0, 0); send_frame(8'h1B, 0, 1, 20);
    push_exp(8'h1B, 0, 0, 1); send_frame(8'h1B, 1, 1, 20);
    drain("R3 odd parity 5 bits");

    dbits = 2'd3; pen = 1'b0; even = 1'b1; stop2 = 1'b0;

    // R4: short low glitch
    rxd = 1'b0; repeat (5) @(negedge clk);
    rxd = 1'b1; repeat (100) @(negedge clk);
    chk_eq("R4 glitch rejected", lsr[0], 0);

    // R6: bad stop followed directly by next data bits
    push_exp(8'h55, 0, 1, 0); push_exp(8'h33, 0, 0, 0);
    send_frame(8'h55, 0, 0, 0);
    send_data(8'h33, 0, 1, 40);
    drain("R6 resync stream");

    // R5: bad stop then idle; resync reads idle as 0xFF
    push_exp(8'hC3, 0, 1, 0); push_exp(8'hFF, 0, 0, 0);
    send_frame(8'hC3, 0, 0, 200);
    drain("R5 framing then idle");

    // R7: all-zero frame exactly one character time low
    push_exp(8'h00, 0, 1, 0);
    send_frame(8'h00, 0, 0, 40);
    drain("R7 boundary zero framing");

    // R7 + R8: long break, then too-short idle before a start
    push_exp(8'h00, 1, 0, 0);
    rxd = 1'b0; repeat (480) @(negedge clk);
    rxd = 1'b1; repeat (4) @(negedge clk);
    send_frame(8'hFF, 0, 1, 60);
    push_exp(8'h3C, 0, 0, 0);
    send_frame(8'h3C, 0, 1, 40);
    drain("R8 break then idle guard");

    // R10: FIFO overrun
    mon_en = 1'b0; lsi_en = 1'b1;
    for (int i = 0; i < 17; i++) begin
      send_frame(8'h40 + 8'(i), 0, 1, 4);
      if (i < 16) push_exp(8'h40 + 8'(i), 0, 0, 0);
    end
    repeat (20) @(negedge clk);
    chk_eq("R10 overrun set", lsr[1], 1);
    chk_eq("R12 irq on overrun", irq, 1);
    pulse_lsr();
    chk_eq("R10 overrun cleared by read", lsr[1], 0);
    chk_eq("R12 irq drops", irq, 0);
    mon_en = 1'b1;
    drain("R10 overrun character discarded");
    chk_eq("R10 FIFO empty after drain", lsr[0], 0);

    // R10/R11: single holding register
    mon_en = 1'b0; fifo_en = 1'b0; lsi_en = 1'b0;
    send_frame(8'h11, 0, 0, 200);
    send_frame(8'h22, 0, 1, 20);
    chk_eq("R10 holding keeps first", rx_data, 8'h11);
    chk_eq("R5 framing shown", lsr[3], 1);
    chk_eq("R10 non-FIFO overrun", lsr[1], 1);
    chk_eq("R11 aggregate off in non-FIFO", lsr[7], 0);
    chk_eq("R12 irq masked", irq, 0);
    pulse_lsr();
    chk_eq("R9 framing cleared by read", lsr[3], 0);
    chk_eq("R10 overrun cleared", lsr[1], 0);
    pulse_dat();
    chk_eq("R10 holding emptied", lsr[0], 0);

    // R9/R11: flags only at head, aggregate bit
    fifo_en = 1'b1;
    send_frame(8'h21, 0, 1, 20);
    send_frame(8'h5A, 0, 0, 200);
    chk_eq("R9 clean head", rx_data, 8'h21);
    chk_eq("R9 flag hidden behind head", lsr[4:2], 3'b000);
    chk_eq("R11 aggregate set", lsr[7], 1);
    pulse_dat();
    chk_eq("R9 flagged char at head", rx_data, 8'h5A);
    chk_eq("R9 framing at head", lsr[3], 1);
    lsi_en = 1'b1;
    @(negedge clk);
    chk_eq("R12 irq on framing", irq, 1);
    pulse_lsr();
    chk_eq("R9 cleared by read", lsr[3], 0);
    chk_eq("R11 aggregate held while flagged queued", lsr[7], 1);
    chk_eq("R12 irq clears", irq, 0);
    pulse_dat();
    chk_eq("R6 resync char after framing", rx_data, 8'hFF);
    chk_eq("R11 aggregate sticky until read", lsr[7], 1);
    pulse_lsr();
    chk_eq("R11 aggregate cleared", lsr[7], 0);
    pulse_dat();
    chk_eq("R2 FIFO empty", lsr[0], 0);
    chk_eq("R1 unused bits zero", lsr[6:5], 2'b00);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule